// File: doc/BRIEF.md
# Multiple-Input Signature Register

This block compacts the responses of a circuit under test into a short signature. On each enabled clock it shifts an internal-XOR linear feedback register by one place and XOR-adds one word of response bits, one bit per stage. After the last word, the signature is a residue of polynomial division of the response stream. For long streams a faulty response matches the good one with a probability near 2^-WIDTH. For example, a 3-bit register fed a 7-bit serial stream misses 15 of the 127 possible faulty streams.

The number of response bits per clock (`NUM_IN`) can be anything from 1 to `WIDTH`. Stages at or above `NUM_IN` get no data XOR, so one register covers both parallel and serial compaction. With `NUM_IN = 1` it acts as a serial-input signature register. The feedback polynomial is a parameter (`TAPS`). A test controller clears the register, streams the responses with `en`, and marks the last word with `done`. That freezes the signature and compares it against a constant expected value supplied on `golden`.

Top module: `misr_core`

## Requirements
- R1: After the asynchronous reset (`rst_n` low), `signature` is all zeros and `frozen` and `pass` are low.
- R2: On an enabled clock (`en` = 1, `clr` = 0, not frozen), stage 0 takes `signature[WIDTH-1] ^ data_in[0]`. Each stage i ≥ 1 takes `signature[i-1] ^ (TAPS[i] & signature[WIDTH-1]) ^ data_in[i]`, where the data term is 0 for i ≥ NUM_IN. `TAPS[0]` is unused.
- R3: With `en` = 0 (and `clr` = 0), `signature` keeps its value whatever `data_in` carries.
- R4: A clock with `done` = 1 (and `clr` = 0) sets `frozen`. If `en` is also 1 and the register was not yet frozen, that cycle's word is folded first. While frozen, `en` and `data_in` have no effect on `signature`.
- R5: `pass` is 1 exactly when `frozen` is 1 and `signature` equals `golden`. It is 0 while not frozen.
- R6: `clr` = 1 on a clock edge zeroes `signature` and clears `frozen`, overriding `en` and `done` in the same cycle.
- R7: With WIDTH = 3, NUM_IN = 1 and TAPS = 3'b100 (polynomial 1 + x^2 + x^3), the serial stream 1,0,0,0 gives signature 3'b101.
- R8: Flipping any single bit of a response stream changes the final signature, so a golden compare on the corrupted stream yields `pass` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of signature and freeze flag |
| en | input | 1 | Fold `data_in` into the signature this clock |
| done | input | 1 | Last word marker; freezes the signature |
| data_in | input | NUM_IN | Response bits, bit i feeds stage i |
| golden | input | WIDTH | Expected good-circuit signature |
| signature | output | WIDTH | Current signature |
| frozen | output | 1 | Signature is frozen |
| pass | output | 1 | Frozen signature equals `golden` |

## Verification
The parallel register is fed several kinds of streams, and each result is compared against a software division model:
- long random streams, which exercise every feedback tap;
- walking-one and all-ones words, which isolate each stage's data XOR;
- an all-zero stream, which shows that a cleared register with no input stays at zero.

Idle cycles carrying random data show that holding does not depend on the inputs. The same stream is run twice, once clean and once with one flipped bit; this tells a correct residue apart from an aliased one and shows `pass` following the golden compare. A 3-bit serial instance checks a hand-worked division and confirms that the unused stages get no data XOR.

// File: rtl/misr_pkg.sv
package misr_pkg;

    parameter int unsigned MISR_DEF_WIDTH = 8;
    // x^8 + x^6 + x^5 + x^4 + 1, internal XOR after stages 3, 4 and 5
    parameter logic [MISR_DEF_WIDTH-1:0] MISR_DEF_TAPS = 8'h70;

    typedef enum logic [1:0] {
        UPD_HOLD  = 2'd0,
        UPD_FOLD  = 2'd1,
        UPD_CLEAR = 2'd2
    } upd_e;

endpackage

// File: rtl/misr_fold.sv
// Combinational next signature: one shift of the internal-XOR register
// plus the parallel data word. Data XORs exist only for used stages.
module misr_fold #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned NUM_IN = 8,
    parameter logic [WIDTH-1:0] TAPS = 8'h70
) (
    input  logic [WIDTH-1:0]  sig_i,
    input  logic [NUM_IN-1:0] data_i,
    output logic [WIDTH-1:0]  sig_o
);
    logic fb;
    logic [WIDTH-1:0] shifted;

    assign fb = sig_i[WIDTH-1];

    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign shifted[i] = fb;
            end else if (TAPS[i]) begin : g_tap
                assign shifted[i] = sig_i[i-1] ^ fb;
            end else begin : g_plain
                assign shifted[i] = sig_i[i-1];
            end

            if (i < NUM_IN) begin : g_data
                assign sig_o[i] = shifted[i] ^ data_i[i];
            end else begin : g_nodata
                assign sig_o[i] = shifted[i];
            end
        end
    endgenerate
endmodule

// File: rtl/misr_compare.sv
module misr_compare #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] sig_i,
    input  logic [WIDTH-1:0] golden_i,
    input  logic             frozen_i,
    output logic             pass_o
);
    logic match;

    assign match  = (sig_i == golden_i);
    assign pass_o = frozen_i & match;
endmodule

// File: rtl/misr_core.sv
module misr_core
    import misr_pkg::*;
#(
    parameter int unsigned WIDTH  = MISR_DEF_WIDTH,
    parameter int unsigned NUM_IN = MISR_DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAPS = MISR_DEF_TAPS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              done,
    input  logic [NUM_IN-1:0] data_in,
    input  logic [WIDTH-1:0]  golden,
    output logic [WIDTH-1:0]  signature,
    output logic              frozen,
    output logic              pass
);
    typedef struct packed {
        logic [WIDTH-1:0] sig;
        logic             frozen;
    } state_t;

    state_t           st_d, st_q;
    logic [WIDTH-1:0] fold_sig;
    upd_e             act;

    misr_fold #(
        .WIDTH (WIDTH),
        .NUM_IN(NUM_IN),
        .TAPS  (TAPS)
    ) i_fold (
        .sig_i (st_q.sig),
        .data_i(data_in),
        .sig_o (fold_sig)
    );

    always_comb begin
        act = UPD_HOLD;
        if (clr) begin
            act = UPD_CLEAR;
        end else if (en && !st_q.frozen) begin
            act = UPD_FOLD;
        end

        st_d = st_q;
        unique case (act)
            UPD_CLEAR: st_d = '0;
            UPD_FOLD:  st_d.sig = fold_sig;
            default:   st_d = st_q;
        endcase

        if (!clr && done) begin
            st_d.frozen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    misr_compare #(
        .WIDTH(WIDTH)
    ) i_cmp (
        .sig_i   (st_q.sig),
        .golden_i(golden),
        .frozen_i(st_q.frozen),
        .pass_o  (pass)
    );

    assign signature = st_q.sig;
    assign frozen    = st_q.frozen;
endmodule

// File: rtl/misr_core_chk.sv
module misr_core_chk #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned NUM_IN = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              en,
    input logic              done,
    input logic [NUM_IN-1:0] data_in,
    input logic [WIDTH-1:0]  golden,
    input logic [WIDTH-1:0]  signature,
    input logic              frozen,
    input logic              pass
);
    p_lsb_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !clr && !frozen) |=>
            (signature[0] == ($past(signature[WIDTH-1]) ^ $past(data_in[0]))));

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !clr) |=> $stable(signature));

    p_freeze_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clr) |=> frozen);

    p_frozen_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !clr) |=> ($stable(signature) && frozen));

    p_pass_gated_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frozen |-> !pass);

    p_pass_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (signature == golden));

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (signature == '0 && !frozen));
endmodule

bind misr_core misr_core_chk #(
    .WIDTH (WIDTH),
    .NUM_IN(NUM_IN)
) i_misr_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .en       (en),
    .done     (done),
    .data_in  (data_in),
    .golden   (golden),
    .signature(signature),
    .frozen   (frozen),
    .pass     (pass)
);

// File: tb/test_misr_core.sv
module test_misr_core;
    localparam int CLK_PERIOD = 10;
    localparam int W  = 8;
    localparam int NI = 8;
    localparam logic [W-1:0] TP = 8'h70;
    localparam int SLEN = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0, en = 1'b0, done = 1'b0;
    logic [NI-1:0] data_in = '0;
    logic [W-1:0]  golden = '0;
    logic [W-1:0]  signature;
    logic          frozen, pass;

    logic          s_clr = 1'b0, s_en = 1'b0;
    logic [0:0]    s_data = 1'b0;
    logic [2:0]    s_sig;
    logic          s_frozen, s_pass;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [W-1:0] sig;
        logic         frz;
        logic         pas;
        string        tag;
    } item_t;
    item_t sb[$];

    logic [W-1:0] exp_sig = '0;
    logic         exp_frz = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    misr_core #(.WIDTH(W), .NUM_IN(NI), .TAPS(TP)) i_misr_core (
        .clk(clk), .rst_n(rst_n), .clr(clr), .en(en), .done(done),
        .data_in(data_in), .golden(golden),
        .signature(signature), .frozen(frozen), .pass(pass)
    );

    misr_core #(.WIDTH(3), .NUM_IN(1), .TAPS(3'b100)) i_misr_serial (
        .clk(clk), .rst_n(rst_n), .clr(s_clr), .en(s_en), .done(1'b0),
        .data_in(s_data), .golden(3'b101),
        .signature(s_sig), .frozen(s_frozen), .pass(s_pass)
    );

    // Division model from R2
    function automatic logic [W-1:0] model(logic [W-1:0] s, logic [NI-1:0] d);
        logic [W-1:0] n;
        logic fb;
        fb = s[W-1];
        n[0] = fb ^ d[0];
        for (int i = 1; i < W; i++) begin
            n[i] = s[i-1] ^ (TP[i] & fb) ^ ((i < NI) ? d[i] : 1'b0);
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Driver: applies one cycle and pushes the expected result
    task automatic drive(input logic c, input logic e, input logic dn,
                         input logic [NI-1:0] d, input string tag);
        item_t it;
        @(negedge clk);
        clr = c; en = e; done = dn; data_in = d;
        if (c) begin
            exp_sig = '0;
            exp_frz = 1'b0;
        end else begin
            if (e && !exp_frz) exp_sig = model(exp_sig, d);
            if (dn) exp_frz = 1'b1;
        end
        @(posedge clk);
        it.sig = exp_sig;
        it.frz = exp_frz;
        it.pas = exp_frz && (exp_sig == golden);
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic drain();
        @(negedge clk);
        clr = 1'b0; en = 1'b0; done = 1'b0;
        while (sb.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: compares design output with the queued expectation
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t it;
            it = sb.pop_front();
            checks++;
            if (signature !== it.sig || frozen !== it.frz || pass !== it.pas) begin
                fails++;
                $display("FAIL %s: actual sig=%h frz=%b pass=%b expected sig=%h frz=%b pass=%b",
                         it.tag, signature, frozen, pass, it.sig, it.frz, it.pas);
            end
        end
    end

    task automatic serial_step(input logic c, input logic e, input logic b);
        @(negedge clk);
        s_clr = c; s_en = e; s_data = b;
        @(posedge clk);
    endtask

    initial begin
        logic [NI-1:0] stream [SLEN];
        logic [W-1:0]  g;
        logic [W-1:0]  sig_a;

        // R1: reset state
        repeat (2) @(negedge clk);
        check(signature == '0, "R1", "reset signature", signature, '0);
        check(!frozen && !pass, "R1", "reset flags", {6'd0, frozen, pass}, '0);
        rst_n = 1'b1;

        drive(1'b1, 1'b0, 1'b0, '0, "R6 initial clear");

        // R2: zero stream, walking ones, all ones, random
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, 1'b0, '0, "R2 zero stream");
        for (int k = 0; k < NI; k++) drive(1'b0, 1'b1, 1'b0, NI'(1) << k, "R2 walking one");
        for (int k = 0; k < 3; k++) drive(1'b0, 1'b1, 1'b0, '1, "R2 all ones");
        for (int k = 0; k < 30; k++) drive(1'b0, 1'b1, 1'b0, NI'($urandom), "R2 random");

        // R3: idle with changing data
        for (int k = 0; k < 6; k++) drive(1'b0, 1'b0, 1'b0, NI'($urandom), "R3 idle hold");

        // R6: clear wins over en and done
        drive(1'b1, 1'b1, 1'b1, '1, "R6 clear over en/done");
        drive(1'b0, 1'b1, 1'b0, 8'h5a, "R2 after clear");
        drain();

        // R4/R5: golden run
        for (int k = 0; k < SLEN; k++) stream[k] = NI'($urandom);
        g = '0;
        for (int k = 0; k < SLEN; k++) g = model(g, stream[k]);
        golden = g;
        drive(1'b1, 1'b0, 1'b0, '0, "R6 clear before golden run");
        for (int k = 0; k < SLEN; k++)
            drive(1'b0, 1'b1, (k == SLEN-1), stream[k], "R4 R5 golden stream");
        for (int k = 0; k < 4; k++) drive(1'b0, 1'b1, 1'b0, NI'($urandom), "R4 frozen ignores data");
        drain();
        sig_a = signature;
        check(pass == 1'b1, "R5", "pass on good stream", {7'd0, pass}, 8'd1);
        check(sig_a == g, "R5", "good signature", sig_a, g);

        // R8: single-bit error
        drive(1'b1, 1'b0, 1'b0, '0, "R6 clear before faulty run");
        for (int k = 0; k < SLEN; k++)
            drive(1'b0, 1'b1, (k == SLEN-1), (k == 5) ? (stream[k] ^ 8'h08) : stream[k],
                  "R8 faulty stream");
        drain();
        check(signature != sig_a, "R8", "signature differs after bit error", signature, ~sig_a);
        check(pass == 1'b0, "R8", "pass low on faulty stream", {7'd0, pass}, 8'd0);

        // R4: done with en low freezes without folding
        drive(1'b1, 1'b0, 1'b0, '0, "R6 clear");
        drive(1'b0, 1'b1, 1'b0, 8'hc3, "R2 word");
        drive(1'b0, 1'b0, 1'b1, 8'hff, "R4 done without en");
        drive(1'b0, 1'b1, 1'b0, 8'h11, "R4 hold after freeze");
        drive(1'b1, 1'b0, 1'b0, '0, "R6 clear unfreezes");
        drain();

        // R7: serial 3-bit register, stream 1,0,0,0 -> 101
        serial_step(1'b1, 1'b0, 1'b0);
        serial_step(1'b0, 1'b1, 1'b1);
        serial_step(1'b0, 1'b1, 1'b0);
        serial_step(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        check(s_sig == 3'b100, "R7", "serial after 3 bits", {5'd0, s_sig}, 8'h04);
        s_en = 1'b1; s_data = 1'b0;
        @(posedge clk);
        @(negedge clk);
        s_en = 1'b0;
        check(s_sig == 3'b101, "R7", "serial signature", {5'd0, s_sig}, 8'h05);
        check(s_pass == 1'b0, "R7", "serial pass needs freeze", {7'd0, s_pass}, 8'd0);

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule